// File: doc/BRIEF.md
# Channel-Indexed Broadcast Register File

This block holds the configuration bytes of a multi-channel converter behind a plain synchronous host port, the kind of port a serial slave front end produces once it has shifted in an address and a data byte. Some registers are stored once per channel. There are four data channels, A to D, and two clock channels: the bit clock and the frame clock. A channel-select register decides which of these copies a write reaches, so a single host write can update one channel, a chosen group of channels, or all of them. The remaining registers are chip-wide. They exist once, and the channel-select register does not affect them.

Reads are registered. A read of a per-channel register returns one channel's copy. When several channels are selected, the lowest-numbered selected channel wins. Bits that a register does not implement are dropped on write and read back as zero. Addresses that hold no register ignore writes and read as zero. Every stored byte is driven out of the block in parallel so that the converter's functions can use it.

Top module: `bcast_regfile`

## Requirements
- R1: After synchronous reset the registers hold these values: channel select 0x3F, monitor threshold 0x80 in every data channel, clock phase 0x03 in both clock channels, interface config 0x18, and every other stored byte 0x00.
- R2: The channel select register sits at 0x005 and keeps bits [5:0]. Bits [3:0] select data channels A, B, C and D in that order. Bit 4 selects the bit-clock channel and bit 5 selects the frame-clock channel. Bits [7:6] always read 0.
- R3: A write to a data-channel register updates the copy in every data channel whose select bit is set and leaves the other copies unchanged. The data-channel registers are power mode at 0x008, test pattern at 0x00D, offset at 0x010 and monitor threshold at 0x109.
- R4: A write to the clock phase register at 0x016 updates the bit-clock copy when select bit 4 is set and the frame-clock copy when select bit 5 is set.
- R5: The chip-wide registers are interface config at 0x000 and sync control at 0x100. Writes and reads of them behave the same whatever the channel select holds.
- R6: A read of a data-channel register returns the copy of the lowest selected channel in the order A, B, C, D. A read of the clock phase register returns the bit-clock copy before the frame-clock copy. With no relevant select bit set, either read returns 0x00.
- R7: Only the implemented bits are stored, and they read back as written: power mode [1:0], test pattern [3:0], offset [7:0], threshold [7:0], clock phase [3:0], interface config [5:2], sync control [2:0]. All other bits read 0.
- R8: Writes to addresses with no register change no stored byte, and reads of them return 0x00. The read-only address 0x001 returns 0xA7 and 0x002 returns 0x20, and writes to them are ignored.
- R9: rdata is loaded on the clock edge where rd_en is sampled high and holds between reads. A read issued in the same cycle as a write returns the value from before that write.
- R10: A write to 0x0FF with bit 0 set raises xfer_pulse for exactly the one cycle after the write edge. Reads of 0x0FF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 9 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| xfer_pulse | output | 1 | One-cycle transfer strobe |
| dch_cfg | output | 128 | Data-channel bytes; channel c, register slot s at bits [(c*4+s)*8 +: 8], slots in the order power, pattern, offset, threshold |
| cch_cfg | output | 16 | Clock phase bytes; bit clock in [7:0], frame clock in [15:8] |
| glb_cfg | output | 16 | Interface config in [7:0], sync control in [15:8] |

## Verification
A wrong channel-select value appears in two ways. A later local write lands in the wrong slices of dch_cfg or cch_cfg on the very next cycle, and a local read returns another channel's byte one cycle after rd_en. A wrongly decoded or unmasked write shows up at once on the parallel outputs as a changed byte or a nonzero unimplemented bit. Read-selection faults show only when a read happens, so the stimulus reads every register under single, multiple and empty channel selections.

// File: rtl/bcast_regs_pkg.sv
package bcast_regs_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int N_DCH  = 4;
  localparam int N_CCH  = 2;
  localparam int N_DLOC = 4;
  localparam int N_CLOC = 1;
  localparam int N_GLB  = 2;
  localparam int SLOT_W = 2;
  localparam int SEL_DCH_LSB = 0;
  localparam int SEL_CCH_LSB = SEL_DCH_LSB + N_DCH;

  localparam logic [DATA_W-1:0] SEL_MASK = 8'h3F;
  localparam logic [DATA_W-1:0] SEL_DFLT = 8'h3F;
  localparam logic [DATA_W-1:0] CHIP_ID  = 8'hA7;
  localparam logic [DATA_W-1:0] CHIP_REV = 8'h20;

  typedef enum logic [2:0] {
    K_NONE, K_RO, K_SEL, K_XFER, K_GLB, K_DLOC, K_CLOC
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot;
  } reg_dec_t;

  function automatic logic [DATA_W-1:0] dloc_mask(input int s);
    logic [DATA_W-1:0] m;
    case (s)
      0:       m = 8'h03;
      1:       m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] dloc_dflt(input int s);
    return (s == 3) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] cloc_mask(input int s);
    return (s == 0) ? 8'h0F : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] cloc_dflt(input int s);
    return (s == 0) ? 8'h03 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] glb_mask(input int s);
    return (s == 0) ? 8'h3C : 8'h07;
  endfunction

  function automatic logic [DATA_W-1:0] glb_dflt(input int s);
    return (s == 0) ? 8'h18 : 8'h00;
  endfunction

  function automatic reg_dec_t decode(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    d.kind = K_NONE;
    d.slot = '0;
    case (a)
      9'h000: begin d.kind = K_GLB;  d.slot = 2'd0; end
      9'h001: begin d.kind = K_RO;   d.slot = 2'd0; end
      9'h002: begin d.kind = K_RO;   d.slot = 2'd1; end
      9'h005: d.kind = K_SEL;
      9'h008: begin d.kind = K_DLOC; d.slot = 2'd0; end
      9'h00D: begin d.kind = K_DLOC; d.slot = 2'd1; end
      9'h010: begin d.kind = K_DLOC; d.slot = 2'd2; end
      9'h016: begin d.kind = K_CLOC; d.slot = 2'd0; end
      9'h0FF: d.kind = K_XFER;
      9'h100: begin d.kind = K_GLB;  d.slot = 2'd1; end
      9'h109: begin d.kind = K_DLOC; d.slot = 2'd3; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/bcast_chan_bank.sv
module bcast_chan_bank
  import bcast_regs_pkg::*;
#(
  parameter int N_REG  = 4,
  parameter bit IS_CLK = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SLOT_W-1:0]       wslot,
  input  logic [DATA_W-1:0]       wdata,
  output logic [N_REG*DATA_W-1:0] regs
);
  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = IS_CLK ? cloc_mask(r) : dloc_mask(r);
    localparam logic [DATA_W-1:0] DFLT = IS_CLK ? cloc_dflt(r) : dloc_dflt(r);
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[r*DATA_W +: DATA_W] <= DFLT;
      end else if (we && (wslot == SLOT_W'(r))) begin
        regs[r*DATA_W +: DATA_W] <= wdata & MASK;
      end
    end
  end
endmodule

// File: rtl/bcast_glb_regs.sv
module bcast_glb_regs
  import bcast_regs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  reg_dec_t                dec,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       sel_q,
  output logic [N_GLB*DATA_W-1:0] glb,
  output logic                    xfer_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= SEL_DFLT;
      xfer_pulse <= 1'b0;
    end else begin
      xfer_pulse <= we && (dec.kind == K_XFER) && wdata[0];
      if (we && (dec.kind == K_SEL)) sel_q <= wdata & SEL_MASK;
    end
  end

  for (genvar g = 0; g < N_GLB; g++) begin : g_glb
    localparam logic [DATA_W-1:0] MASK = glb_mask(g);
    localparam logic [DATA_W-1:0] DFLT = glb_dflt(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        glb[g*DATA_W +: DATA_W] <= DFLT;
      end else if (we && (dec.kind == K_GLB) && (dec.slot == SLOT_W'(g))) begin
        glb[g*DATA_W +: DATA_W] <= wdata & MASK;
      end
    end
  end
endmodule

// File: rtl/bcast_rd_sel.sv
module bcast_rd_sel
  import bcast_regs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           re,
  input  reg_dec_t                       dec,
  input  logic [DATA_W-1:0]              sel_q,
  input  logic [N_DCH*N_DLOC*DATA_W-1:0] dch_regs,
  input  logic [N_CCH*N_CLOC*DATA_W-1:0] cch_regs,
  input  logic [N_GLB*DATA_W-1:0]        glb,
  output logic [DATA_W-1:0]              rdata
);
  logic [DATA_W-1:0] dval, cval, gval, nxt;

  // Walk from the highest channel down so the lowest selected one is kept.
  always_comb begin
    dval = '0;
    for (int c = N_DCH - 1; c >= 0; c--) begin
      if (sel_q[SEL_DCH_LSB + c]) begin
        dval = dch_regs[(c*N_DLOC + int'(dec.slot))*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    cval = '0;
    for (int k = N_CCH - 1; k >= 0; k--) begin
      if (sel_q[SEL_CCH_LSB + k]) begin
        cval = cch_regs[k*N_CLOC*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    gval = glb[0 +: DATA_W];
    for (int g = 1; g < N_GLB; g++) begin
      if (dec.slot == SLOT_W'(g)) gval = glb[g*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (dec.kind)
      K_RO:    nxt = (dec.slot == '0) ? CHIP_ID : CHIP_REV;
      K_SEL:   nxt = sel_q;
      K_GLB:   nxt = gval;
      K_DLOC:  nxt = dval;
      K_CLOC:  nxt = cval;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= nxt;
  end
endmodule

// File: rtl/bcast_regfile.sv
module bcast_regfile
  import bcast_regs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic                           xfer_pulse,
  output logic [N_DCH*N_DLOC*DATA_W-1:0] dch_cfg,
  output logic [N_CCH*N_CLOC*DATA_W-1:0] cch_cfg,
  output logic [N_GLB*DATA_W-1:0]        glb_cfg
);
  localparam int DBANK_W = N_DLOC * DATA_W;
  localparam int CBANK_W = N_CLOC * DATA_W;

  reg_dec_t          dec;
  logic [DATA_W-1:0] sel_q;
  logic [N_DCH-1:0]  dch_we;
  logic [N_CCH-1:0]  cch_we;

  assign dec = decode(addr);

  bcast_glb_regs u_glb (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_en),
    .dec        (dec),
    .wdata      (wdata),
    .sel_q      (sel_q),
    .glb        (glb_cfg),
    .xfer_pulse (xfer_pulse)
  );

  for (genvar c = 0; c < N_DCH; c++) begin : g_dch
    assign dch_we[c] = wr_en && (dec.kind == K_DLOC) && sel_q[SEL_DCH_LSB + c];
    bcast_chan_bank #(.N_REG(N_DLOC), .IS_CLK(1'b0)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (dch_we[c]),
      .wslot (dec.slot),
      .wdata (wdata),
      .regs  (dch_cfg[c*DBANK_W +: DBANK_W])
    );
  end

  for (genvar k = 0; k < N_CCH; k++) begin : g_cch
    assign cch_we[k] = wr_en && (dec.kind == K_CLOC) && sel_q[SEL_CCH_LSB + k];
    bcast_chan_bank #(.N_REG(N_CLOC), .IS_CLK(1'b1)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (cch_we[k]),
      .wslot (dec.slot),
      .wdata (wdata),
      .regs  (cch_cfg[k*CBANK_W +: CBANK_W])
    );
  end

  bcast_rd_sel u_rd (
    .clk      (clk),
    .rst      (rst),
    .re       (rd_en),
    .dec      (dec),
    .sel_q    (sel_q),
    .dch_regs (dch_cfg),
    .cch_regs (cch_cfg),
    .glb      (glb_cfg),
    .rdata    (rdata)
  );
endmodule

// File: rtl/bcast_regfile_chk.sv
module bcast_regfile_chk
  import bcast_regs_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [ADDR_W-1:0]              addr,
  input logic [DATA_W-1:0]              wdata,
  input logic [DATA_W-1:0]              rdata,
  input logic                           xfer_pulse,
  input logic [N_DCH*N_DLOC*DATA_W-1:0] dch_cfg,
  input logic [N_CCH*N_CLOC*DATA_W-1:0] cch_cfg,
  input logic [N_GLB*DATA_W-1:0]        glb_cfg,
  input logic [DATA_W-1:0]              sel_q
);
  localparam int DBANK_W = N_DLOC * DATA_W;

  reg_dec_t cdec;
  assign cdec = decode(addr);

  p_sel_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == 8'h3F));

  p_sel_upper_r2: assert property (@(posedge clk) disable iff (rst)
    sel_q[7:6] == 2'b00);

  p_bcast_a_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 9'h109 && sel_q[0]) |=> (dch_cfg[3*DATA_W +: DATA_W] == $past(wdata)));

  p_isolate_b_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cdec.kind == K_DLOC && !sel_q[1]) |=> $stable(dch_cfg[DBANK_W +: DBANK_W]));

  p_glb_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 9'h100) |=> (glb_cfg[DATA_W +: DATA_W] == ($past(wdata) & 8'h07)));

  p_none_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cdec.kind == K_NONE) |=> ($stable(dch_cfg) && $stable(cch_cfg) && $stable(glb_cfg)));

  p_none_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cdec.kind == K_NONE) |=> (rdata == 8'h00));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_xfer_src_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |-> $past(wr_en && addr == 9'h0FF && wdata[0]));
endmodule

bind bcast_regfile bcast_regfile_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .xfer_pulse (xfer_pulse),
  .dch_cfg    (dch_cfg),
  .cch_cfg    (cch_cfg),
  .glb_cfg    (glb_cfg),
  .sel_q      (sel_q)
);

// File: tb/bcast_regfile_tb.sv
module bcast_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [8:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         xfer_pulse;
  logic [127:0] dch_cfg;
  logic [15:0]  cch_cfg;
  logic [15:0]  glb_cfg;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_sel;
  logic [7:0] m_d [4][4];
  logic [7:0] m_c [2];
  logic [7:0] m_g [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_regfile u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .xfer_pulse(xfer_pulse),
    .dch_cfg(dch_cfg), .cch_cfg(cch_cfg), .glb_cfg(glb_cfg)
  );

  function automatic int dslot(input logic [8:0] a);
    case (a)
      9'h008:  return 0;
      9'h00D:  return 1;
      9'h010:  return 2;
      9'h109:  return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] dmask(input int s);
    case (s)
      0:       return 8'h03;
      1:       return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [127:0] pack_d();
    logic [127:0] v;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        v[(c*4+s)*8 +: 8] = m_d[c][s];
    return v;
  endfunction

  function automatic logic [7:0] model_read(input logic [8:0] a);
    int s;
    s = dslot(a);
    if (s >= 0) begin
      for (int c = 0; c < 4; c++) if (m_sel[c]) return m_d[c][s];
      return 8'h00;
    end
    case (a)
      9'h000:  return m_g[0];
      9'h100:  return m_g[1];
      9'h001:  return 8'hA7;
      9'h002:  return 8'h20;
      9'h005:  return m_sel;
      9'h016:  return m_sel[4] ? m_c[0] : (m_sel[5] ? m_c[1] : 8'h00);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_sel = 8'h3F;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        m_d[c][s] = (s == 3) ? 8'h80 : 8'h00;
    m_c[0] = 8'h03;
    m_c[1] = 8'h03;
    m_g[0] = 8'h18;
    m_g[1] = 8'h00;
  endtask

  task automatic model_write(input logic [8:0] a, input logic [7:0] d);
    int s;
    s = dslot(a);
    if (s >= 0) begin
      for (int c = 0; c < 4; c++) if (m_sel[c]) m_d[c][s] = d & dmask(s);
    end else begin
      case (a)
        9'h000: m_g[0] = d & 8'h3C;
        9'h100: m_g[1] = d & 8'h07;
        9'h005: m_sel = d & 8'h3F;
        9'h016: for (int k = 0; k < 2; k++) if (m_sel[4+k]) m_c[k] = d & 8'h0F;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check(tag, "dch_cfg", dch_cfg, pack_d());
    check(tag, "cch_cfg", {112'd0, cch_cfg}, {112'd0, m_c[1], m_c[0]});
    check(tag, "glb_cfg", {112'd0, glb_cfg}, {112'd0, m_g[1], m_g[0]});
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check_outputs(tag);
    check("R10", "xfer_pulse", {127'd0, xfer_pulse}, {127'd0, (a == 9'h0FF) && d[0]});
  endtask

  task automatic do_read(input logic [8:0] a, input string tag);
    logic [7:0] exp;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, $sformatf("rdata @%0h", a), {120'd0, rdata}, {120'd0, exp});
  endtask

  function automatic logic [8:0] pick_addr(input int i);
    case (i)
      0: return 9'h000;  1: return 9'h001;  2: return 9'h002;  3: return 9'h005;
      4: return 9'h008;  5: return 9'h00D;  6: return 9'h010;  7: return 9'h016;
      8: return 9'h0FF;  9: return 9'h100; 10: return 9'h109; 11: return 9'h003;
     12: return 9'h013; 13: return 9'h0FE; 14: return 9'h101; 15: return 9'h1FF;
      default: return 9'h109;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values at the ports and through reads
    check_outputs("R1");
    do_read(9'h005, "R1");
    do_read(9'h109, "R6");

    // R3 broadcast to all channels
    do_write(9'h109, 8'h5A, "R3");
    // R2 select one channel, R3 only C changes
    do_write(9'h005, 8'h04, "R2");
    do_write(9'h010, 8'h33, "R3");
    do_read(9'h010, "R6");
    // R7 masking, B and D selected
    do_write(9'h005, 8'h0A, "R2");
    do_write(9'h00D, 8'hFF, "R7");
    do_read(9'h00D, "R6");
    do_write(9'h008, 8'hFF, "R7");
    // empty selection
    do_write(9'h005, 8'h00, "R2");
    do_read(9'h109, "R6");
    do_write(9'h109, 8'h11, "R3");
    do_read(9'h016, "R6");
    // R4 clock channels
    do_write(9'h005, 8'h20, "R2");
    do_write(9'h016, 8'hA9, "R4");
    do_read(9'h016, "R4");
    do_write(9'h005, 8'h30, "R2");
    do_read(9'h016, "R6");
    do_write(9'h005, 8'hFF, "R2");
    do_read(9'h005, "R2");
    // R5 globals with empty selection
    do_write(9'h005, 8'h00, "R2");
    do_write(9'h100, 8'hFF, "R5");
    do_read(9'h100, "R5");
    do_write(9'h000, 8'hFF, "R7");
    do_read(9'h000, "R5");
    // R8 unimplemented and read-only
    do_write(9'h013, 8'hFF, "R8");
    do_write(9'h1FF, 8'hFF, "R8");
    do_read(9'h013, "R8");
    do_read(9'h1FF, "R8");
    do_write(9'h001, 8'h00, "R8");
    do_read(9'h001, "R8");
    do_read(9'h002, "R8");
    // R10 transfer strobe
    do_write(9'h0FF, 8'h01, "R10");
    @(negedge clk);
    check("R10", "xfer_pulse low", {127'd0, xfer_pulse}, 128'd0);
    do_read(9'h0FF, "R10");
    // R9 read and write in the same cycle, then hold
    held = model_read(9'h100);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 9'h100; wdata = 8'h05;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(9'h100, 8'h05);
    check("R9", "rdata old value", {120'd0, rdata}, {120'd0, held});
    do_read(9'h100, "R9");
    held = rdata;
    addr = 9'h001;
    repeat (3) @(negedge clk);
    check("R9", "rdata held", {120'd0, rdata}, {120'd0, held});

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [8:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 4);
      a  = pick_addr($urandom_range(0, 16));
      d  = 8'($urandom_range(0, 255));
      if (op <= 1)      do_write(a, d, "R3");
      else if (op == 2) do_write(9'h005, d, "R2");
      else              do_read(a, "R6");
    end

    finish_run();
  end
endmodule